// File: doc/BRIEF.md
# I2C Master Receive Byte Engine

This block is the receive half of an I2C bus master. Software first writes a control register that holds a bit count and an acknowledge enable. It then commands a start condition. From that point, every read of the data buffer clocks in one more transfer from the addressed slave. The engine drives SCL from a programmable low/high phase divider. It samples SDA in the middle of each SCL high phase, most significant bit first. If acknowledge is enabled, it adds one more clock during which it pulls SDA low.

At the end of every transfer the engine raises an interrupt. The value returned by a data buffer read is always the last completed transfer, so the read that starts the first transfer returns a value that software throws away. To end a read, software turns acknowledge off before it reads the second-to-last word. It then selects a bit count of one and reads once more. This produces a lone clock with SDA released, which the transmitter sees as a NACK. A stop command then releases the bus. Slave mode, transmit, arbitration and clock stretching are not part of the block.

Top module: `i2c_rx_engine`

## Requirements
- R1: After reset SCL and SDA are released (scl_o=1, sda_oe=0), busy=0 and irq=0. A control read (rd_sel=1) returns 8'h01: bit 0 is ack enable, bits 3:1 are the bit count, and bits 7:4 read zero.
- R2: A control write with bit 4 set while the bus is idle starts a start condition. SDA is driven low for HIGH_CYC cycles with SCL high, then SCL goes low and SDA is released. busy is 1 from the first of these cycles.
- R3: A data read (rd_en=1, rd_sel=0) while the bus is held between transfers starts one transfer. The read returns the last completed transfer, so the first read after setup returns a dummy value. A data read while the bus is idle clocks nothing.
- R4: A transfer clocks n data bits, where n is the bit count and 3'b000 means 8. Each bit gets one SCL pulse of LOW_CYC low and HIGH_CYC high cycles. Bits are taken MSB first, and the result sits right-aligned in the data buffer with its upper bits zero.
- R5: With ack enable 1, one extra SCL pulse follows the data bits, and SDA is driven low for that whole bit. With ack enable 0 there is no extra pulse. The master never drives SDA during data bits, so a 1-bit transfer with ack off leaves SDA released as a NACK.
- R6: irq is set when each transfer ends, including 1-bit transfers. It is cleared by a data read or a control write.
- R7: A data read during a transfer returns the last completed value. It neither restarts nor lengthens the transfer in flight.
- R8: A control write with bit 5 set while the bus is held starts a stop. SDA goes low with SCL low, then SCL is released, then SDA is released with SCL high. busy stays 1 until SDA is released.
- R9: A stop command is ignored unless the bus is held between transfers. A start command is ignored unless the bus is idle.
- R10: During a transfer, sda_oe changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_wr | input | 1 | Control write strobe |
| ctrl_wdata | input | 6 | Bit 0 ack enable, bits 3:1 bit count, bit 4 start command, bit 5 stop command |
| rd_en | input | 1 | Read strobe |
| rd_sel | input | 1 | Read select: 0 data buffer, 1 control |
| rd_data | output | 8 | Read data, valid combinationally for the current rd_sel |
| irq | output | 1 | Transfer-complete interrupt |
| busy | output | 1 | Bus owned, from start until stop completes |
| scl_o | output | 1 | SCL level (1 released, 0 driven low) |
| sda_oe | output | 1 | Drive SDA low when 1 |
| sda_i | input | 1 | Sampled SDA line |

## Verification
The bench builds the engine with LOW_CYC=4 and HIGH_CYC=4, so one bit takes 8 cycles and one 8-bit transfer with acknowledge takes 72. At that length, the bench can sweep every data value for every bit count from 1 to 8, with acknowledge both on and off, well inside the cycle budget. A slave model on the bench side shifts out each value, counts SCL pulses and watches SDA during the acknowledge slot. A closing pass then runs a full three-word read with the software NACK and the stop sequence.

// File: rtl/i2c_rx_engine.sv
module i2c_rx_engine #(
  parameter int LOW_CYC  = 8,
  parameter int HIGH_CYC = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctrl_wr,
  input  logic [5:0] ctrl_wdata,
  input  logic       rd_en,
  input  logic       rd_sel,
  output logic [7:0] rd_data,
  output logic       irq,
  output logic       busy,
  output logic       scl_o,
  output logic       sda_oe,
  input  logic       sda_i
);
  localparam int MAXC = (LOW_CYC > HIGH_CYC) ? LOW_CYC : HIGH_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] LOW_END  = CW'(LOW_CYC - 1);
  localparam logic [CW-1:0] HIGH_END = CW'(HIGH_CYC - 1);
  localparam logic [CW-1:0] MID      = CW'(HIGH_CYC / 2);

  typedef enum logic [2:0] {S_IDLE, S_STA, S_HOLD, S_LOW, S_HIGH, S_SP1, S_SP2} st_t;

  st_t           state;
  logic [CW-1:0] cnt;
  logic [3:0]    bitn, nbits;
  logic          ack_cur, ack_en;
  logic [2:0]    bc;
  logic [7:0]    sh, dbr;

  wire data_rd    = rd_en && !rd_sel;
  wire in_idle    = state == S_IDLE;
  wire in_hold    = state == S_HOLD;
  wire in_xfer    = state == S_LOW || state == S_HIGH;
  wire ack_slot   = bitn == nbits;
  wire data_phase = in_xfer && !ack_slot;
  wire [3:0] last_bit = ack_cur ? nbits : nbits - 4'd1;
  wire phase_end  = cnt == ((state == S_LOW || state == S_SP1) ? LOW_END : HIGH_END);

  assign scl_o   = !(in_hold || state == S_LOW || state == S_SP1);
  assign sda_oe  = state == S_STA || state == S_SP1 || state == S_SP2 ||
                   (in_xfer && ack_slot && ack_cur);
  assign busy    = !in_idle;
  assign rd_data = rd_sel ? {4'b0000, bc, ack_en} : dbr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      cnt     <= '0;
      bitn    <= '0;
      nbits   <= 4'd8;
      ack_cur <= 1'b0;
      ack_en  <= 1'b1;
      bc      <= 3'b000;
      sh      <= '0;
      dbr     <= '0;
      irq     <= 1'b0;
    end else begin
      if (ctrl_wr) {bc, ack_en} <= ctrl_wdata[3:0];
      if (ctrl_wr || data_rd) irq <= 1'b0;
      cnt <= phase_end ? '0 : cnt + 1'b1;
      case (state)
        S_IDLE: begin
          cnt <= '0;
          if (ctrl_wr && ctrl_wdata[4]) state <= S_STA;
        end
        S_STA: if (phase_end) state <= S_HOLD;
        S_HOLD: begin
          cnt <= '0;
          if (data_rd) begin
            state   <= S_LOW;
            bitn    <= '0;
            sh      <= '0;
            ack_cur <= ack_en;
            nbits   <= (bc == 3'b000) ? 4'd8 : {1'b0, bc};
          end else if (ctrl_wr && ctrl_wdata[5]) begin
            state <= S_SP1;
          end
        end
        S_LOW: if (phase_end) state <= S_HIGH;
        S_HIGH: begin
          if (cnt == MID && data_phase) sh <= {sh[6:0], sda_i};
          if (phase_end) begin
            if (bitn == last_bit) begin
              dbr   <= sh;
              irq   <= 1'b1;
              state <= S_HOLD;
            end else begin
              bitn  <= bitn + 4'd1;
              state <= S_LOW;
            end
          end
        end
        S_SP1: if (phase_end) state <= S_SP2;
        S_SP2: if (phase_end) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_rx_engine_chk.sv
module i2c_rx_engine_chk (
  input logic clk,
  input logic rst_n,
  input logic in_idle,
  input logic in_hold,
  input logic in_xfer,
  input logic data_phase,
  input logic scl_o,
  input logic sda_oe,
  input logic busy,
  input logic irq,
  input logic data_rd,
  input logic start_wr,
  input logic stop_wr
);
  assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (scl_o && !sda_oe));

  assert_start_drives_sda_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_idle && start_wr) |=> (busy && scl_o && sda_oe));

  assert_xfer_from_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_xfer) |-> $past(in_hold && data_rd));

  assert_no_drive_on_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    data_phase |-> !sda_oe);

  assert_irq_after_xfer_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(in_xfer));

  assert_stop_ignored_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_idle && stop_wr && !start_wr) |=> in_idle);

  assert_sda_stable_scl_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_xfer && scl_o && $past(scl_o)) |-> $stable(sda_oe));
endmodule

bind i2c_rx_engine i2c_rx_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_idle(in_idle), .in_hold(in_hold),
  .in_xfer(in_xfer), .data_phase(data_phase), .scl_o(scl_o), .sda_oe(sda_oe),
  .busy(busy), .irq(irq), .data_rd(data_rd),
  .start_wr(ctrl_wr && ctrl_wdata[4]), .stop_wr(ctrl_wr && ctrl_wdata[5])
);

// File: tb/sim_i2c_rx_engine.sv
`timescale 1ns/1ps
module sim_i2c_rx_engine;
  localparam int LC = 4, HC = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ctrl_wr = 1'b0, rd_en = 1'b0, rd_sel = 1'b0;
  logic [5:0] ctrl_wdata = '0;
  logic [7:0] rd_data;
  logic irq, busy, scl_o, sda_oe, sda_i;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  logic [7:0] tx_val = '0;
  int tx_n = 8, idx = 0, pulses = 0;
  bit ack_seen = 1'b0, drove = 1'b0;
  logic slave_bit;

  always #2 clk = ~clk;

  i2c_rx_engine #(.LOW_CYC(LC), .HIGH_CYC(HC)) u0 (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
    .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data), .irq(irq), .busy(busy),
    .scl_o(scl_o), .sda_oe(sda_oe), .sda_i(sda_i));

  assign slave_bit = (idx < tx_n) ? tx_val[3'(tx_n - 1 - idx)] : 1'b1;
  assign sda_i = !sda_oe && slave_bit;

  always @(negedge scl_o) idx = idx + 1;
  always @(posedge scl_o) begin
    pulses = pulses + 1;
    if (idx == tx_n && sda_oe) ack_seen = 1'b1;
    if (idx < tx_n && sda_oe) drove = 1'b1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr_ctrl(input logic [5:0] d);
    @(negedge clk); ctrl_wr = 1'b1; ctrl_wdata = d;
    @(negedge clk); ctrl_wr = 1'b0;
  endtask

  task automatic rd_dat(output logic [7:0] d);
    @(negedge clk); rd_sel = 1'b0; rd_en = 1'b1; d = rd_data;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic slave_arm(input int n, input logic [7:0] v);
    tx_n = n; tx_val = v; idx = 0; pulses = 0; ack_seen = 1'b0; drove = 1'b0;
  endtask

  task automatic wait_irq();
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (irq) break;
    end
    chk(irq === 1'b1, "R6 irq at end of transfer", int'(irq), 1);
  endtask

  task automatic do_xfer(input int n, input bit a, input logic [7:0] v,
                         input logic [7:0] prev, input bit mid_rd);
    logic [7:0] got;
    wr_ctrl({2'b00, 3'(n % 8), a});
    slave_arm(n, v);
    rd_dat(got);
    chk(got == prev, "R3 read returns previous", got, prev);
    chk(irq === 1'b0, "R6 irq cleared by read", int'(irq), 0);
    if (mid_rd) begin
      repeat (LC + 2) @(negedge clk);
      rd_dat(got);
      chk(got == prev, "R7 mid-transfer read", got, prev);
    end
    wait_irq();
    chk(pulses == n + int'(a), "R4 pulse count", pulses, n + int'(a));
    if (a) chk(ack_seen, "R5 ack driven low", int'(ack_seen), 1);
    chk(!drove, "R5 no drive on data", int'(drove), 0);
    rd_sel = 1'b0; #0;
    chk(rd_data == v, "R4 received value", rd_data, v);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] got, prev;
    int p, pmax;
    bit seen1, seen2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd_sel = 1'b1; #0;
    chk(rd_data == 8'h01, "R1 control reset value", rd_data, 8'h01);
    chk(scl_o && !sda_oe, "R1 bus released", {scl_o, sda_oe}, 2);
    chk(!busy && !irq, "R1 busy/irq low", {busy, irq}, 0);

    // R9: stop while idle is ignored
    slave_arm(8, 8'h00);
    wr_ctrl(6'b100001);
    repeat (12) @(negedge clk);
    chk(scl_o && !sda_oe && !busy, "R9 stop ignored when idle", {scl_o, sda_oe, busy}, 4);
    // R3: data read while idle clocks nothing
    rd_dat(got);
    repeat (20) @(negedge clk);
    chk(pulses == 0 && !busy, "R3 idle read clocks nothing", pulses, 0);

    // R2: start condition
    wr_ctrl(6'b010001);
    chk(busy && scl_o && sda_oe, "R2 start SDA low SCL high", {busy, scl_o, sda_oe}, 7);
    repeat (HC) @(negedge clk);
    chk(busy && !scl_o && !sda_oe, "R2 start then SCL low", {busy, scl_o, sda_oe}, 4);
    wr_ctrl(6'b010001);
    repeat (4) @(negedge clk);
    chk(busy && !scl_o && !sda_oe, "R9 start ignored when held", {busy, scl_o, sda_oe}, 4);

    prev = 8'h00;
    for (int n = 1; n <= 8; n++)
      for (int a = 0; a <= 1; a++)
        for (int v = 0; v < (1 << n); v++) begin
          do_xfer(n, a[0], 8'(v), prev, (v % 37) == 3);
          prev = 8'(v);
        end

    // full read with software NACK: words A5, 3C, C3
    wr_ctrl(6'b000001);
    slave_arm(8, 8'hA5);
    rd_dat(got);
    chk(got == prev, "R3 dummy read", got, prev);
    repeat (10) @(negedge clk);
    wr_ctrl(6'b100001);
    wait_irq();
    chk(pulses == 9, "R9 stop ignored during transfer", pulses, 9);
    slave_arm(8, 8'h3C);
    rd_dat(got);
    chk(got == 8'hA5, "R3 first word", got, 8'hA5);
    wait_irq();
    chk(pulses == 9 && ack_seen, "R5 ack on second word", pulses, 9);
    wr_ctrl(6'b000000);
    slave_arm(8, 8'hC3);
    rd_dat(got);
    chk(got == 8'h3C, "R3 second word", got, 8'h3C);
    wait_irq();
    chk(pulses == 8, "R5 no ack clock", pulses, 8);
    wr_ctrl(6'b000010);
    slave_arm(1, 8'h01);
    rd_dat(got);
    chk(got == 8'hC3, "R3 last word", got, 8'hC3);
    wait_irq();
    chk(pulses == 1, "R4 single-bit transfer", pulses, 1);
    chk(!drove, "R5 NACK leaves SDA released", int'(drove), 0);
    rd_sel = 1'b0; #0;
    chk(rd_data == 8'h01, "R4 single-bit result", rd_data, 1);

    // R8: stop sequence ordering
    wr_ctrl(6'b100010);
    pmax = 0; seen1 = 1'b0; seen2 = 1'b0;
    for (int i = 0; i < 50 && busy; i++) begin
      p = (!scl_o && sda_oe) ? 1 : (scl_o && sda_oe) ? 2 : (scl_o && !sda_oe) ? 3 : 0;
      if (p == 1) seen1 = 1'b1;
      if (p == 2) seen2 = 1'b1;
      chk(p >= pmax && p != 0 && p != 3, "R8 stop phase order", p, pmax);
      if (p > pmax) pmax = p;
      @(negedge clk);
    end
    chk(seen1 && seen2, "R8 stop phases seen", {seen1, seen2}, 3);
    chk(!busy && scl_o && !sda_oe, "R8 bus released after stop", {busy, scl_o, sda_oe}, 2);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule